// File: doc/BRIEF.md
# Compact-to-Wide Instruction Expander

This block rewrites a 16-bit compact instruction halfword into the matching 32-bit data-processing or trap instruction word. Downstream decode logic then needs to understand only the wide encoding. The block is purely combinational. A halfword is presented on the input, and the expanded word and a valid flag appear in the same cycle.

Three groups of halfwords are handled:
- the trap (software interrupt) form;
- the eight-bit-immediate group: move, compare, add and subtract;
- the two-operand register ALU group.

For every word it produces, the block fills in the unconditional condition code and sets the flag-update bit explicitly. It also pads each 3-bit register number to 4 bits and zero-pads immediates. Two-address register forms are turned into three-address forms by repeating the destination as the first source. A halfword outside the supported subset drives the valid flag low and the word to zero.

Top module: `hw_expander`

## Requirements
- R1: Every word produced with the valid flag high carries 1110 in bits 31:28.
- R2: A halfword whose bits 15:8 equal 0xDF yields valid high and the word 0xEF000000 OR'ed with the halfword's bits 7:0.
- R3: A halfword with 001 in bits 15:13 yields valid high and a word with these fields:
  - bits 27:26 = 00, bit 25 = 1, bit 20 = 1;
  - bits 11:8 = 0, and bits 7:0 copying halfword bits 7:0;
  - an opcode in bits 24:21 chosen by halfword bits 12:11 (00→1101, 01→1010, 10→0100, 11→0010).
- R4: For the immediate move (bits 12:11 = 00), bits 19:16 are zero and bits 15:12 equal {0, halfword bits 10:8}.
- R5: For the immediate compare (bits 12:11 = 01), bits 15:12 are zero and bits 19:16 equal {0, halfword bits 10:8}.
- R6: For the immediate add and subtract (bits 12:11 = 10 or 11), bits 19:16 and bits 15:12 both equal {0, halfword bits 10:8}.
- R7: A halfword with 010000 in bits 15:10 and a supported op code in bits 9:6 yields valid high and a word with these fields:
  - bits 27:25 = 000, bit 20 = 1, bits 11:4 = 0;
  - bits 3:0 = {0, halfword bits 5:3};
  - bits 24:21 equal to the op code.
  - The supported op codes are 0000, 0001, 0101, 0110, 1000, 1010, 1011, 1100, 1110 and 1111.
- R8: For register ops 0000, 0001, 0101, 0110, 1100 and 1110, both bits 19:16 and bits 15:12 equal {0, halfword bits 2:0}.
- R9: For register test ops 1000, 1010 and 1011, bits 15:12 are zero and bits 19:16 equal {0, halfword bits 2:0}. For op 1111, bits 19:16 are zero and bits 15:12 equal {0, halfword bits 2:0}.
- R10: Register-group op codes 0010, 0011, 0100, 0111, 1001 and 1101 (shifts, rotate, negate, multiply) yield valid low and an all-zero word.
- R11: Any halfword matching none of the three groups yields valid low and an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Compact instruction halfword to expand |
| word_o | output | 32 | Expanded wide instruction word, zero when not valid |
| valid_o | output | 1 | High when the halfword belongs to the supported subset |

## Verification
The checker assumes only that the input halfword is a settled, fully known value; every 16-bit pattern is legal stimulus. The assertions are evaluated once the combinational paths have settled after each change of input. The stimulus meets these assumptions by driving a new halfword on one clock edge and sampling on the opposite edge. The sweep covers all 65,536 halfwords, so every group, every op code and every register and immediate value reaches the checker.

// File: rtl/hwx_pkg.sv
package hwx_pkg;

    localparam int HW_W    = 16;
    localparam int WORD_W  = 32;
    localparam int NREG_W  = 3;
    localparam int REG_W   = 4;
    localparam int IMM_W   = 8;
    localparam int OP2_W   = 12;
    localparam int N_GROUP = 3;

    localparam logic [3:0]       COND_ALWAYS = 4'b1110;
    localparam logic [IMM_W-1:0] TRAP_TAG    = 8'hDF;
    localparam logic [2:0]       IMM_TAG     = 3'b001;
    localparam logic [5:0]       ALU_TAG     = 6'b010000;
    localparam logic [7:0]       TRAP_TOP    = 8'hEF;

    typedef enum logic [3:0] {
        DP_AND = 4'd0,  DP_EOR = 4'd1,  DP_SUB = 4'd2,  DP_RSB = 4'd3,
        DP_ADD = 4'd4,  DP_ADC = 4'd5,  DP_SBC = 4'd6,  DP_RSC = 4'd7,
        DP_TST = 4'd8,  DP_TEQ = 4'd9,  DP_CMP = 4'd10, DP_CMN = 4'd11,
        DP_ORR = 4'd12, DP_MOV = 4'd13, DP_BIC = 4'd14, DP_MVN = 4'd15
    } dp_op_e;

    // How the single compact register field is placed in the wide word
    typedef enum logic [1:0] {
        ROLE_BOTH = 2'd0,   // destination and first source
        ROLE_TEST = 2'd1,   // first source only, destination zero
        ROLE_MOVE = 2'd2    // destination only, first source zero
    } reg_role_e;

    typedef struct packed {
        logic [3:0]       cond;
        logic [1:0]       cls;
        logic             imm;
        dp_op_e           opc;
        logic             setf;
        logic [REG_W-1:0] rn;
        logic [REG_W-1:0] rd;
        logic [OP2_W-1:0] op2;
    } dp_word_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } xl_res_t;

    typedef struct packed {
        logic   ok;
        dp_op_e opc;
    } alu_map_t;

    function automatic logic [REG_W-1:0] widen_reg(input logic [NREG_W-1:0] r);
        return {{(REG_W-NREG_W){1'b0}}, r};
    endfunction

    function automatic reg_role_e role_of(input dp_op_e op);
        case (op)
            DP_TST, DP_TEQ, DP_CMP, DP_CMN: return ROLE_TEST;
            DP_MOV, DP_MVN:                 return ROLE_MOVE;
            default:                        return ROLE_BOTH;
        endcase
    endfunction

    function automatic dp_word_t build_dp(input logic imm, input dp_op_e op,
                                          input logic [NREG_W-1:0] r,
                                          input logic [OP2_W-1:0] op2);
        dp_word_t w;
        w.cond = COND_ALWAYS;
        w.cls  = 2'b00;
        w.imm  = imm;
        w.opc  = op;
        w.setf = 1'b1;
        w.op2  = op2;
        case (role_of(op))
            ROLE_TEST: begin w.rn = widen_reg(r); w.rd = '0;           end
            ROLE_MOVE: begin w.rn = '0;           w.rd = widen_reg(r); end
            default:   begin w.rn = widen_reg(r); w.rd = widen_reg(r); end
        endcase
        return w;
    endfunction

    // Register ALU group: compact op code -> wide opcode, or reject
    function automatic alu_map_t alu_lookup(input logic [3:0] t);
        alu_map_t m;
        m.ok = 1'b1;
        case (t)
            4'h0:    m.opc = DP_AND;
            4'h1:    m.opc = DP_EOR;
            4'h5:    m.opc = DP_ADC;
            4'h6:    m.opc = DP_SBC;
            4'h8:    m.opc = DP_TST;
            4'hA:    m.opc = DP_CMP;
            4'hB:    m.opc = DP_CMN;
            4'hC:    m.opc = DP_ORR;
            4'hE:    m.opc = DP_BIC;
            4'hF:    m.opc = DP_MVN;
            default: begin m.ok = 1'b0; m.opc = DP_AND; end
        endcase
        return m;
    endfunction

    function automatic dp_op_e imm_lookup(input logic [1:0] k);
        case (k)
            2'd0:    return DP_MOV;
            2'd1:    return DP_CMP;
            2'd2:    return DP_ADD;
            default: return DP_SUB;
        endcase
    endfunction

endpackage

// File: rtl/hwx_trap_xlat.sv
module hwx_trap_xlat
    import hwx_pkg::*;
(
    input  logic [HW_W-1:0] insn_i,
    output xl_res_t         res_o
);
    logic hit;

    always_comb begin
        hit         = (insn_i[HW_W-1:IMM_W] == TRAP_TAG);
        res_o.valid = hit;
        res_o.word  = '0;
        if (hit) begin
            res_o.word = {TRAP_TOP, {(WORD_W-2*IMM_W){1'b0}}, insn_i[IMM_W-1:0]};
        end
    end
endmodule

// File: rtl/hwx_imm_xlat.sv
module hwx_imm_xlat
    import hwx_pkg::*;
(
    input  logic [HW_W-1:0] insn_i,
    output xl_res_t         res_o
);
    logic     hit;
    dp_op_e   op;
    dp_word_t w;

    always_comb begin
        hit         = (insn_i[15:13] == IMM_TAG);
        op          = imm_lookup(insn_i[12:11]);
        w           = build_dp(1'b1, op, insn_i[10:8],
                               {{(OP2_W-IMM_W){1'b0}}, insn_i[IMM_W-1:0]});
        res_o.valid = hit;
        res_o.word  = hit ? WORD_W'(w) : '0;
    end
endmodule

// File: rtl/hwx_alu_xlat.sv
module hwx_alu_xlat
    import hwx_pkg::*;
(
    input  logic [HW_W-1:0] insn_i,
    output xl_res_t         res_o
);
    logic     hit;
    alu_map_t m;
    dp_word_t w;

    always_comb begin
        hit         = (insn_i[15:10] == ALU_TAG);
        m           = alu_lookup(insn_i[9:6]);
        w           = build_dp(1'b0, m.opc, insn_i[2:0],
                               {{(OP2_W-REG_W){1'b0}}, widen_reg(insn_i[5:3])});
        res_o.valid = hit && m.ok;
        res_o.word  = (hit && m.ok) ? WORD_W'(w) : '0;
    end
endmodule

// File: rtl/hw_expander.sv
module hw_expander
    import hwx_pkg::*;
(
    input  logic [15:0] insn_i,
    output logic [31:0] word_o,
    output logic        valid_o
);
    xl_res_t res [N_GROUP];

    hwx_trap_xlat u_trap (.insn_i(insn_i), .res_o(res[0]));
    hwx_imm_xlat  u_imm  (.insn_i(insn_i), .res_o(res[1]));
    hwx_alu_xlat  u_alu  (.insn_i(insn_i), .res_o(res[2]));

    // Group tags are disjoint, and each translator zeroes its word when it
    // does not claim the halfword, so a plain OR merges the results.
    logic [WORD_W-1:0] word_acc  [N_GROUP+1];
    logic              valid_acc [N_GROUP+1];

    assign word_acc[0]  = '0;
    assign valid_acc[0] = 1'b0;

    for (genvar g = 0; g < N_GROUP; g++) begin : g_merge
        assign word_acc[g+1]  = word_acc[g]  | res[g].word;
        assign valid_acc[g+1] = valid_acc[g] | res[g].valid;
    end

    assign word_o  = word_acc[N_GROUP];
    assign valid_o = valid_acc[N_GROUP];
endmodule

// File: rtl/hw_expander_chk.sv
module hw_expander_chk (
    input logic [15:0] insn_i,
    input logic [31:0] word_o,
    input logic        valid_o
);
    always_comb begin
        p_cond_always_r1: assert (!valid_o || word_o[31:28] == 4'b1110)
            else $error("R1 condition field wrong");
        p_zero_reject_r11: assert (valid_o || word_o == 32'h0)
            else $error("R11 rejected halfword left a nonzero word");
        p_trap_pad_r2: assert (!(insn_i[15:8] == 8'hDF) ||
                               (valid_o && word_o[27:8] == 20'hF0000 &&
                                word_o[7:0] == insn_i[7:0]))
            else $error("R2 trap word wrong");
        p_imm_shape_r3: assert (!(insn_i[15:13] == 3'b001) ||
                                (valid_o && word_o[27:25] == 3'b001 && word_o[20] &&
                                 word_o[11:8] == 4'h0 && word_o[7:0] == insn_i[7:0]))
            else $error("R3 immediate word shape wrong");
        p_alu_shape_r7: assert (!(insn_i[15:10] == 6'b010000 && valid_o) ||
                                (word_o[27:25] == 3'b000 && word_o[20] &&
                                 word_o[11:4] == 8'h00 &&
                                 word_o[3:0] == {1'b0, insn_i[5:3]} &&
                                 word_o[24:21] == insn_i[9:6]))
            else $error("R7 register word shape wrong");
        p_reg_pad_r6: assert (!valid_o || insn_i[15:8] == 8'hDF ||
                              (word_o[19] == 1'b0 && word_o[15] == 1'b0))
            else $error("R6 register fields not zero padded");
    end
endmodule

bind hw_expander hw_expander_chk chk_i (
    .insn_i (insn_i),
    .word_o (word_o),
    .valid_o(valid_o)
);

// File: tb/hw_expander_tb_top.sv
module hw_expander_tb_top;

    logic        clk = 1'b0;
    logic [15:0] insn;
    logic [31:0] word;
    logic        valid;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hw_expander dut_i (.insn_i(insn), .word_o(word), .valid_o(valid));

    task automatic check(input string tag, input logic [15:0] h,
                         input logic [31:0] ew, input logic ev);
        n_checks++;
        if (word !== ew || valid !== ev) begin
            n_fail++;
            $display("FAIL %s insn=%04h got word=%08h valid=%0b exp word=%08h valid=%0b",
                     tag, h, word, valid, ew, ev);
        end
    endtask

    // Expected result built arithmetically from the requirement text
    task automatic expect_of(input logic [15:0] h, output logic [31:0] ew,
                             output logic ev, output string tag);
        int code, rn, rd, t;
        ew = 32'h0; ev = 1'b0; tag = "R11";
        if (h[15:8] == 8'hDF) begin
            ew = 32'hEF00_0000 + h[7:0]; ev = 1'b1; tag = "R2/R1";
        end else if (h[15:13] == 3'b001) begin
            t = h[12:11];
            code = (t == 0) ? 13 : (t == 1) ? 10 : (t == 2) ? 4 : 2;
            rn = (t == 0) ? 0 : h[10:8];
            rd = (t == 1) ? 0 : h[10:8];
            ew = 32'hE000_0000 + (1 << 25) + (code << 21) + (1 << 20) +
                 (rn << 16) + (rd << 12) + h[7:0];
            ev = 1'b1;
            tag = (t == 0) ? "R3/R4" : (t == 1) ? "R3/R5" : "R3/R6";
        end else if (h[15:10] == 6'b010000) begin
            t = h[9:6];
            if (t == 2 || t == 3 || t == 4 || t == 7 || t == 9 || t == 13) begin
                tag = "R10";
            end else begin
                rn = (t == 15) ? 0 : h[2:0];
                rd = (t == 8 || t == 10 || t == 11) ? 0 : h[2:0];
                ew = 32'hE000_0000 + (t << 21) + (1 << 20) +
                     (rn << 16) + (rd << 12) + h[5:3];
                ev = 1'b1;
                tag = (t == 8 || t == 10 || t == 11 || t == 15) ? "R7/R9" : "R7/R8";
            end
        end
    endtask

    task automatic apply(input logic [15:0] h);
        logic [31:0] ew;
        logic        ev;
        string       tag;
        @(posedge clk);
        insn = h;
        @(negedge clk);
        expect_of(h, ew, ev, tag);
        check(tag, h, ew, ev);
        if (ev) begin
            n_checks++;   // R1: condition nibble on every valid word
            if (word[31:28] !== 4'b1110) begin
                n_fail++;
                $display("FAIL R1 insn=%04h got cond=%0h exp cond=e", h, word[31:28]);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        insn = 16'h0000;
        @(negedge clk);
        check("R11 idle", 16'h0000, 32'h0, 1'b0);
        // Directed corner cases
        apply(16'hDF00);   // R2 smallest trap
        apply(16'hDFFF);   // R2 largest trap
        apply(16'hDE12);   // R11 neighbour of the trap tag
        apply(16'h20FF);   // R4 move r0
        apply(16'h2F80);   // R5 compare r7
        apply(16'h3501);   // R6 add r5
        apply(16'h3E7F);   // R6 subtract r6
        apply(16'h43C0);   // R9 op 1111 with r0
        apply(16'h4280);   // R9 compare regs
        apply(16'h4340);   // R10 multiply
        apply(16'h4080);   // R10 shift
        apply(16'h4388);   // R8 clear-bits
        // Exhaustive sweep over every halfword
        for (int i = 0; i < 65536; i++) apply(i[15:0]);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got running exp finished");
            finish_run();
        end
    end

endmodule